// File: doc/BRIEF.md
# Windowed DC Level Change Detector

This block watches 16-bit two's-complement samples that arrive one at a time, each tagged with the channel it belongs to. It compares every sample it accepts against a window centred on a signed reference level. The window extends by an unsigned margin on either side. Each channel keeps a one-bit status flag, where 0 means no change and 1 means the sample fell outside the window.

Each channel is configured in one of two modes. In DC level change mode, its flag is sticky and stays set until the host clears it. In signal detection mode, its flag simply follows the result for the most recent sample accepted on that channel.

The block has two ways of choosing which channel it evaluates:
- In manual operation, the host names the channel.
- In scan operation, the block keeps its own channel pointer. The pointer steps through the channels set to DC change mode, one step per valid sample, and the sample source follows that pointer.

Any flag going from 0 to 1 produces a one-cycle change event, which feeds an interrupt controller.

Top module: `dc_window_detector`

## Requirements
- R1: After a synchronous active-low reset, all flags are 0, `change_evt` is 0 and `scan_ch` is 0.
- R2: A sample is outside the window when it is greater than ref_level + diff_level or less than ref_level − diff_level. Here ref_level and the sample are signed, and diff_level is unsigned. A sample equal to either bound is inside. The flag is updated at the clock edge where `smp_valid` is sampled high.
- R3: The window bounds are computed without overflow for every ref_level in [−32768, 32767] and every diff_level in [0, 65535].
- R4: A channel with `ch_mode` bit = 1 (DC change mode) keeps its flag at 1 after it is set, through any later in-window samples, until it is cleared.
- R5: A channel with `ch_mode` bit = 0 (signal detection mode) takes, for its flag, the out-of-window result of each sample evaluated on it.
- R6: `clr_flags` bit i clears flag i at the next edge. If the same edge evaluates channel i, the evaluation result takes precedence.
- R7: `change_evt` is high for exactly the cycles that immediately follow an edge where at least one flag went from 0 to 1. A flag that stays at 1 produces no event.
- R8: With `scan_en` = 0, only a valid sample whose `smp_ch` equals `host_ch` is evaluated. Samples for other channels leave all flags unchanged, and `scan_ch` holds.
- R9: With `scan_en` = 1, every valid sample moves `scan_ch` to the next channel, in increasing order and wrapping, whose `ch_mode` bit is 1. A sample is evaluated only if its `smp_ch` equals `scan_ch` and that channel is in DC change mode.
- R10: With `scan_en` = 1 and no channel in DC change mode, `scan_ch` holds and no flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_level | input | 16 | Signed window centre |
| diff_level | input | 16 | Unsigned window half-width |
| ch_mode | input | NUM_CH | Per-channel mode, 1 = DC change, 0 = signal detection |
| scan_en | input | 1 | 1 = scan operation, 0 = manual operation |
| host_ch | input | CH_W | Channel chosen by the host in manual operation |
| smp_valid | input | 1 | Sample strobe |
| smp_ch | input | CH_W | Channel tag of the sample |
| smp_data | input | 16 | Two's-complement sample |
| clr_flags | input | NUM_CH | Per-channel flag clear |
| flags | output | NUM_CH | Per-channel change status |
| scan_ch | output | CH_W | Channel pointer used in scan operation |
| change_evt | output | 1 | One-cycle pulse on any flag rising |

## Verification
The bench sweeps samples exactly on, just inside and just outside both bounds, for several reference/margin pairs that include the extreme corners. A design with an off-by-one comparison would flag a sample sitting exactly on a bound. A design with a narrow sum would wrap and produce a window that is inverted or empty. The bench also checks that a DC-mode flag survives in-window samples, that a clear which coincides with a new excursion leaves the flag set, and that a mistagged sample changes nothing. In scan operation the pointer is followed over several passes across a sparse channel mask; a design that skipped incorrectly or forgot to wrap would visit a signal-detection channel or stall.

// File: rtl/dcwd_pkg.sv
// Shared definitions for the windowed DC level change detector.
// Assumes samples are two's-complement and the margin is unsigned.
package dcwd_pkg;
    // Extra bits on top of the sample width so that ref +/- diff cannot wrap.
    localparam int GUARD_BITS = 2;

    // Per-channel mode encoding as presented on ch_mode.
    typedef enum logic {
        MODE_SIGDET = 1'b0,
        MODE_DCCHG  = 1'b1
    } ch_mode_e;
endpackage

// File: rtl/dcwd_window_cmp.sv
// Combinational window test: reports whether a signed sample lies
// strictly outside [ref - diff, ref + diff]. Bounds are inclusive.
// Assumes ref and sample are signed and diff is unsigned, all SAMPLE_W wide.
module dcwd_window_cmp #(
    parameter int SAMPLE_W = 16
) (
    input  logic [SAMPLE_W-1:0] sample,
    input  logic [SAMPLE_W-1:0] ref_lvl,
    input  logic [SAMPLE_W-1:0] diff_lvl,
    output logic                outside
);
    import dcwd_pkg::*;
    localparam int EW = SAMPLE_W + GUARD_BITS;

    logic signed [EW-1:0] s_w, r_w, d_w, lo_w, hi_w;

    // Widen the operands and form both bounds, then compare.
    always_comb begin
        s_w     = $signed({{GUARD_BITS{sample[SAMPLE_W-1]}}, sample});
        r_w     = $signed({{GUARD_BITS{ref_lvl[SAMPLE_W-1]}}, ref_lvl});
        d_w     = $signed({{GUARD_BITS{1'b0}}, diff_lvl});
        lo_w    = r_w - d_w;
        hi_w    = r_w + d_w;
        outside = (s_w < lo_w) || (s_w > hi_w);
    end
endmodule

// File: rtl/dcwd_scan_ptr.sv
// Scan pointer: in scan operation, each valid sample moves the pointer to
// the next channel (ascending, wrapping) whose mode bit is DC change.
// Holds when no such channel exists, and always holds in manual operation.
module dcwd_scan_ptr #(
    parameter int NUM_CH = 4,
    parameter int CH_W   = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scan_en,
    input  logic              adv,
    input  logic [NUM_CH-1:0] dc_mask,
    output logic [CH_W-1:0]   ptr
);
    logic [CH_W-1:0] nxt;

    // Search from farthest to nearest so the nearest DC channel wins.
    always_comb begin
        nxt = ptr;
        for (int k = NUM_CH; k >= 1; k--) begin
            int idx;
            idx = (int'(ptr) + k) % NUM_CH;
            if (dc_mask[idx]) nxt = CH_W'(idx);
        end
    end

    // Pointer register.
    always_ff @(posedge clk) begin
        if (!rst_n)             ptr <= '0;
        else if (scan_en && adv) ptr <= nxt;
    end
endmodule

// File: rtl/dcwd_flag_bank.sv
// Per-channel status flags plus the rising-edge change event.
// DC-mode flags are sticky; signal-mode flags track the last evaluation.
// An evaluation on the same edge as a clear takes precedence.
module dcwd_flag_bank #(
    parameter int NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] hit,
    input  logic              outside,
    input  logic [NUM_CH-1:0] dc_mask,
    input  logic [NUM_CH-1:0] clr,
    output logic [NUM_CH-1:0] flags,
    output logic              evt
);
    logic [NUM_CH-1:0] nxt;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        // Next-state rule for one channel flag.
        always_comb begin
            if (dc_mask[g]) begin
                if (hit[g] && outside) nxt[g] = 1'b1;
                else if (clr[g])       nxt[g] = 1'b0;
                else                   nxt[g] = flags[g];
            end else begin
                if (hit[g])      nxt[g] = outside;
                else if (clr[g]) nxt[g] = 1'b0;
                else             nxt[g] = flags[g];
            end
        end

        // Flag register.
        always_ff @(posedge clk) begin
            if (!rst_n) flags[g] <= 1'b0;
            else        flags[g] <= nxt[g];
        end
    end

    // Event register: high after any 0-to-1 flag transition.
    always_ff @(posedge clk) begin
        if (!rst_n) evt <= 1'b0;
        else        evt <= |(nxt & ~flags);
    end
endmodule

// File: rtl/dc_window_detector.sv
// Top of the windowed DC level change detector. Picks the channel to
// evaluate (host choice or scan pointer), gates the window test onto that
// channel's flag and emits a change event. Assumes NUM_CH >= 2.
module dc_window_detector #(
    parameter int NUM_CH   = 4,
    parameter int SAMPLE_W = 16,
    localparam int CH_W    = $clog2(NUM_CH)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SAMPLE_W-1:0] ref_level,
    input  logic [SAMPLE_W-1:0] diff_level,
    input  logic [NUM_CH-1:0]   ch_mode,
    input  logic                scan_en,
    input  logic [CH_W-1:0]     host_ch,
    input  logic                smp_valid,
    input  logic [CH_W-1:0]     smp_ch,
    input  logic [SAMPLE_W-1:0] smp_data,
    input  logic [NUM_CH-1:0]   clr_flags,
    output logic [NUM_CH-1:0]   flags,
    output logic [CH_W-1:0]     scan_ch,
    output logic                change_evt
);
    logic [CH_W-1:0]   sel_ch;
    logic              eval;
    logic              outside;
    logic [NUM_CH-1:0] hit;

    // Choose the channel under test and decide whether this sample counts.
    always_comb begin
        sel_ch = scan_en ? scan_ch : host_ch;
        eval   = smp_valid && (smp_ch == sel_ch) &&
                 (!scan_en || ch_mode[sel_ch]);
        for (int i = 0; i < NUM_CH; i++)
            hit[i] = eval && (smp_ch == CH_W'(i));
    end

    dcwd_window_cmp #(.SAMPLE_W(SAMPLE_W)) cmp_i (
        .sample   (smp_data),
        .ref_lvl  (ref_level),
        .diff_lvl (diff_level),
        .outside  (outside)
    );

    dcwd_scan_ptr #(.NUM_CH(NUM_CH), .CH_W(CH_W)) scan_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .scan_en (scan_en),
        .adv     (smp_valid),
        .dc_mask (ch_mode),
        .ptr     (scan_ch)
    );

    dcwd_flag_bank #(.NUM_CH(NUM_CH)) flag_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit     (hit),
        .outside (outside),
        .dc_mask (ch_mode),
        .clr     (clr_flags),
        .flags   (flags),
        .evt     (change_evt)
    );
endmodule

// File: rtl/dcwd_checker.sv
// Property checker for dc_window_detector, attached by bind below.
module dcwd_checker #(
    parameter int NUM_CH = 4,
    parameter int CH_W   = $clog2(NUM_CH)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_CH-1:0] ch_mode,
    input logic              scan_en,
    input logic              smp_valid,
    input logic [NUM_CH-1:0] clr_flags,
    input logic [NUM_CH-1:0] flags,
    input logic [CH_W-1:0]   scan_ch,
    input logic              change_evt
);
    // R7
    evt_has_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        change_evt |-> ((flags & ~$past(flags)) != '0));

    // R2
    no_rise_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> ((flags & ~$past(flags)) == '0));

    // R8
    ptr_hold_manual_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !scan_en |=> $stable(scan_ch));

    // R9
    ptr_hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> $stable(scan_ch));

    // R10
    ptr_hold_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_mode == '0) |=> $stable(scan_ch));

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
        // R4
        sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (flags[g] && ch_mode[g] && !clr_flags[g]) |=> flags[g]);

        // R6
        clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_flags[g] && !smp_valid) |=> !flags[g]);
    end
endmodule

bind dc_window_detector dcwd_checker #(.NUM_CH(NUM_CH)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .ch_mode    (ch_mode),
    .scan_en    (scan_en),
    .smp_valid  (smp_valid),
    .clr_flags  (clr_flags),
    .flags      (flags),
    .scan_ch    (scan_ch),
    .change_evt (change_evt)
);

// File: tb/dc_window_detector_tb_top.sv
`timescale 1ns/1ps
module dc_window_detector_tb_top;
    localparam int NCH = 4;
    localparam int CW  = 2;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [15:0]     ref_level, diff_level, smp_data;
    logic [NCH-1:0]  ch_mode, clr_flags, flags;
    logic            scan_en, smp_valid, change_evt;
    logic [CW-1:0]   host_ch, smp_ch, scan_ch;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    logic [NCH-1:0] m_flags;
    logic [CW-1:0]  m_ptr;
    int ref_i, diff_i;

    always #2 clk = ~clk;

    dc_window_detector #(.NUM_CH(NCH), .SAMPLE_W(16)) dut_i (
        .clk(clk), .rst_n(rst_n), .ref_level(ref_level), .diff_level(diff_level),
        .ch_mode(ch_mode), .scan_en(scan_en), .host_ch(host_ch),
        .smp_valid(smp_valid), .smp_ch(smp_ch), .smp_data(smp_data),
        .clr_flags(clr_flags), .flags(flags), .scan_ch(scan_ch),
        .change_evt(change_evt)
    );

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int clamp16(int v);
        if (v > 32767)  return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    // Apply one cycle of stimulus at a negedge, update the model, check at next negedge.
    task automatic step(bit v, int tag, int data, logic [NCH-1:0] clr, string req);
        logic [NCH-1:0] nf;
        int sel;
        bit ev, outside;
        smp_valid = v; smp_ch = CW'(tag); smp_data = 16'(data); clr_flags = clr;
        sel = scan_en ? int'(m_ptr) : int'(host_ch);
        ev = v && (tag == sel) && (!scan_en || ch_mode[sel]);
        outside = (data > ref_i + diff_i) || (data < ref_i - diff_i);
        for (int i = 0; i < NCH; i++) begin
            bit h;
            h = ev && (tag == i);
            if (ch_mode[i]) nf[i] = (h && outside) ? 1'b1 : (clr[i] ? 1'b0 : m_flags[i]);
            else            nf[i] = h ? outside : (clr[i] ? 1'b0 : m_flags[i]);
        end
        if (scan_en && v) begin
            for (int k = NCH; k >= 1; k--)
                if (ch_mode[(int'(m_ptr) + k) % NCH]) m_ptr = CW'((int'(m_ptr) + k) % NCH);
        end
        @(negedge clk);
        check({req, " flags"}, flags, nf);
        check({"R7 evt"}, change_evt, |(nf & ~m_flags));
        check({req, " scan_ch"}, scan_ch, m_ptr);
        m_flags = nf;
        smp_valid = 0; clr_flags = '0;
    endtask

    task automatic set_win(int r, int d);
        ref_i = r; diff_i = d;
        ref_level = 16'(r); diff_level = 16'(d);
    endtask

    initial begin
        int refs  [6] = '{0, 100, -200, 32767, -32768, 7};
        int diffs [6] = '{0, 5, 1000, 65535, 65535, 0};
        rst_n = 0; smp_valid = 0; smp_ch = 0; smp_data = 0; clr_flags = 0;
        ch_mode = 0; scan_en = 0; host_ch = 0;
        set_win(0, 0);
        m_flags = 0; m_ptr = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check("R1 flags", flags, 0);
        check("R1 evt", change_evt, 0);
        check("R1 scan_ch", scan_ch, 0);

        // R2 R3 R5: boundary sweep in signal detection mode, manual operation
        for (int p = 0; p < 6; p++) begin
            int pts [7];
            set_win(refs[p], diffs[p]);
            host_ch = CW'(p % NCH);
            pts = '{clamp16(refs[p]-diffs[p]-1), clamp16(refs[p]-diffs[p]),
                    clamp16(refs[p]+diffs[p]), clamp16(refs[p]+diffs[p]+1),
                    -32768, 32767, 0};
            for (int s = 0; s < 7; s++)
                step(1, p % NCH, pts[s], '0, (p >= 3) ? "R3" : "R2");
        end
        // Dense sweep around a small window
        set_win(-3, 4); host_ch = 1;
        for (int s = -12; s <= 12; s++) step(1, 1, s, '0, "R5");

        // R4 sticky in DC mode
        step(0, 0, 0, '1, "R6");
        ch_mode = 4'b0010; set_win(50, 10); host_ch = 1;
        step(1, 1, 61, '0, "R4");
        step(1, 1, 50, '0, "R4");
        step(1, 1, 40, '0, "R4");
        step(0, 0, 0, '0, "R4");
        // R6 clear, and set-over-clear
        step(0, 0, 0, 4'b0010, "R6");
        step(1, 1, 39, 4'b0010, "R6");
        step(1, 1, 45, 4'b0010, "R6");

        // R8 mistagged samples in manual mode
        ch_mode = 4'b1111; host_ch = 2;
        step(1, 3, -30000, '0, "R8");
        step(1, 0, 30000, '0, "R8");
        step(1, 2, 30000, '0, "R8");
        step(0, 0, 0, '1, "R6");

        // R9 scan over a sparse mask
        ch_mode = 4'b1010; scan_en = 1;
        for (int n = 0; n < 10; n++) begin
            step(1, int'(scan_ch), (n % 2) ? 0 : 1000, '0, "R9");
            if (n == 5) step(0, 0, 0, '1, "R9");
        end
        // Mistagged sample in scan: pointer still advances, nothing evaluated
        step(1, int'(scan_ch) ^ 1, 5000, '0, "R9");
        ch_mode = 4'b0001;
        for (int n = 0; n < 3; n++) step(1, int'(scan_ch), 2000, '0, "R9");

        // R10 scan with no DC channels
        step(0, 0, 0, '1, "R6");
        ch_mode = 4'b0000;
        for (int n = 0; n < 4; n++) step(1, n, 5000, '0, "R10");

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule